// File: doc/BRIEF.md
# Delta-Sigma Fractional-N Modulus Controller

This block feeds a multi-modulus feedback divider. On every divided-clock cycle strobe it issues one integer modulus, and over many cycles the mean of those moduli equals a programmed integer plus a binary fraction. A third-order cascade of three first-order accumulators (1-1-1) produces the dither. Its combined carries push the modulus between about three below and four above the integer word, and they shape the quantisation error toward high offset frequencies.

The fraction has either 18 or 10 significant bits, chosen by a resolution select. Software writes the dividend in two parts. The writes land in shadow registers and become active together, so a half-updated fraction never reaches the modulator. A separate signed modulation offset is added to the channel word in real time, after two register stages on the block clock. An integer mode bypasses the dither altogether.

Top module: `fracn_div_ctrl`

## Requirements
- R1: After synchronous reset the modulus output is 32, the active integer word is 32 and the active fraction is zero. With these values the modulus stays 32 under strobes in fractional mode.
- R2: The modulus output changes only on a clock edge at which `cyc_i` is high. Without a strobe it holds its value, whatever writes occur.
- R3: In 18-bit mode the fraction F is {`fhi_data`,`flo_data`}, with the high part in bits 17:8 and the low part in bits 7:0. Over any 8192 consecutive strobes with constant settings, the sum of moduli equals (N·2^18 + F)·8192/2^18 to within ±3.
- R4: In 10-bit mode (`res_fine_i` = 0) only the high part is used and fraction bits 7:0 are taken as zero. The low part then has no effect on the mean.
- R5: In fractional mode each modulus lies between E−3 and E+4. E is the integer part of the effective word N·2^18 + F + offset.
- R6: With `int_mode_i` = 1, every strobe yields exactly the active integer word, and the modulation offset has no effect.
- R7: `mod_off_i` is a 12-bit two's-complement offset added to the fraction. Its unit is 1 LSB of an 18-bit fraction in 18-bit mode and 2^8 of those LSBs in 10-bit mode. A sum below zero or above 2^18−1 borrows from or carries into the integer part. The input passes through two clock stages before use.
- R8: A write to the high part alone leaves the active fraction unchanged.
- R9: A low-part write or an integer-word write arms a commit. All shadow words then become active on the next strobe. A new value first appears in the modulus produced by the second strobe after the write.
- R10: An integer word written below 32 is stored as 32, and one written above 543 is stored as 543.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (reference domain) |
| rst | input | 1 | Synchronous active-high reset |
| nint_wr | input | 1 | Write strobe for the integer word shadow |
| nint_data | input | 10 | Integer divide word |
| fhi_wr | input | 1 | Write strobe for the high dividend part |
| fhi_data | input | 10 | Dividend bits 17:8 |
| flo_wr | input | 1 | Write strobe for the low dividend part (arms commit) |
| flo_data | input | 8 | Dividend bits 7:0 |
| res_fine_i | input | 1 | 1: 18-bit fraction, 0: 10-bit fraction |
| int_mode_i | input | 1 | 1: dither bypassed, modulus = integer word |
| mod_off_i | input | 12 | Signed modulation offset sample |
| cyc_i | input | 1 | One strobe per divided-clock cycle |
| modulus_o | output | 10 | Instantaneous divider modulus |

## Verification
A corrupted accumulator, or a carry that is lost, does not show up in any single output value, because one modulus inside the −3..+4 band looks plausible. It shows up as a shifted mean over a whole accumulator period. For that reason the main checks sum the modulus over 8192 strobes and compare the sum with the exact value to within three counts. A commit logic error shows within two strobes: either a stale mean appears or the integer word changes a strobe too early. A wrong integer-mode or saturation path shows on the very first strobe after the change.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int DEF_NINT_W   = 10;
    localparam int DEF_HI_W     = 10;
    localparam int DEF_LO_W     = 8;
    localparam int DEF_MOD_W    = 12;
    localparam int DEF_NINT_MIN = 32;
    localparam int DEF_NINT_MAX = 543;
    localparam int DITH_W       = 4;

    typedef enum logic {
        RES_COARSE = 1'b0,
        RES_FINE   = 1'b1
    } res_mode_e;

    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
    } carry_t;

    typedef struct packed {
        logic c2_d;
        logic c3_d;
        logic c3_dd;
    } carry_hist_t;

    // Third-order cascade carry recombination: c1 + d(c2) + d2(c3)
    function automatic logic signed [DITH_W-1:0] mash_combine(
        input carry_t      c,
        input carry_hist_t h
    );
        logic signed [DITH_W-1:0] r;
        r = '0;
        if (c.c1)    r = r + 4'sd1;
        if (c.c2)    r = r + 4'sd1;
        if (h.c2_d)  r = r - 4'sd1;
        if (c.c3)    r = r + 4'sd1;
        if (h.c3_d)  r = r - 4'sd2;
        if (h.c3_dd) r = r + 4'sd1;
        return r;
    endfunction

endpackage

// File: rtl/fracn_word_stage.sv
module fracn_word_stage
    import fracn_pkg::*;
#(
    parameter int NINT_W   = DEF_NINT_W,
    parameter int HI_W     = DEF_HI_W,
    parameter int LO_W     = DEF_LO_W,
    parameter int NINT_MIN = DEF_NINT_MIN,
    parameter int NINT_MAX = DEF_NINT_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nint_wr,
    input  logic [NINT_W-1:0] nint_data,
    input  logic              fhi_wr,
    input  logic [HI_W-1:0]   fhi_data,
    input  logic              flo_wr,
    input  logic [LO_W-1:0]   flo_data,
    input  logic              cyc_i,
    output logic [NINT_W-1:0] act_nint,
    output logic [HI_W-1:0]   act_hi,
    output logic [LO_W-1:0]   act_lo
);

    localparam logic [NINT_W-1:0] MIN_V = NINT_W'(NINT_MIN);
    localparam logic [NINT_W-1:0] MAX_V = NINT_W'(NINT_MAX);

    logic [NINT_W-1:0] sh_nint;
    logic [HI_W-1:0]   sh_hi;
    logic [LO_W-1:0]   sh_lo;
    logic              pend_q;
    logic [NINT_W-1:0] nint_clamped;
    logic              commit;

    always_comb begin
        if (nint_data < MIN_V)
            nint_clamped = MIN_V;
        else if (nint_data > MAX_V)
            nint_clamped = MAX_V;
        else
            nint_clamped = nint_data;
    end

    assign commit = cyc_i && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_nint <= MIN_V;
            sh_hi   <= '0;
            sh_lo   <= '0;
        end else begin
            if (nint_wr) sh_nint <= nint_clamped;
            if (fhi_wr)  sh_hi   <= fhi_data;
            if (flo_wr)  sh_lo   <= flo_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (nint_wr || flo_wr)
            pend_q <= 1'b1;
        else if (cyc_i)
            pend_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_nint <= MIN_V;
            act_hi   <= '0;
            act_lo   <= '0;
        end else if (commit) begin
            act_nint <= sh_nint;
            act_hi   <= sh_hi;
            act_lo   <= sh_lo;
        end
    end

    // R9
    commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cyc_i && !nint_wr && !flo_wr) |=> !pend_q);

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cyc_i && pend_q) |=> ($stable(act_hi) && $stable(act_lo) && $stable(act_nint)));

    // R10
    nint_range_chk: assert property (@(posedge clk) disable iff (rst)
        (act_nint >= MIN_V) && (act_nint <= MAX_V));

endmodule

// File: rtl/fracn_mod_sync.sv
module fracn_mod_sync #(
    parameter int MOD_W  = 12,
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [MOD_W-1:0] mod_in,
    output logic signed [MOD_W-1:0] mod_out
);

    logic signed [MOD_W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= mod_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign mod_out = stage_q[STAGES-1];

endmodule

// File: rtl/fracn_mash3.sv
module fracn_mash3
    import fracn_pkg::*;
#(
    parameter int FRAC_W = DEF_HI_W + DEF_LO_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic                     clr,
    input  logic [FRAC_W-1:0]        x_in,
    output logic signed [DITH_W-1:0] dith
);

    logic [FRAC_W-1:0] acc1_q, acc2_q, acc3_q;
    logic [FRAC_W:0]   s1, s2, s3;
    carry_t            cy;
    carry_hist_t       hist_q;

    always_comb begin
        s1    = {1'b0, acc1_q} + {1'b0, x_in};
        s2    = {1'b0, acc2_q} + {1'b0, s1[FRAC_W-1:0]};
        s3    = {1'b0, acc3_q} + {1'b0, s2[FRAC_W-1:0]};
        cy.c1 = s1[FRAC_W];
        cy.c2 = s2[FRAC_W];
        cy.c3 = s3[FRAC_W];
    end

    assign dith = mash_combine(cy, hist_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc1_q <= '0;
            acc2_q <= '0;
            acc3_q <= '0;
            hist_q <= '0;
        end else if (adv) begin
            acc1_q       <= s1[FRAC_W-1:0];
            acc2_q       <= s2[FRAC_W-1:0];
            acc3_q       <= s3[FRAC_W-1:0];
            hist_q.c2_d  <= cy.c2;
            hist_q.c3_d  <= cy.c3;
            hist_q.c3_dd <= hist_q.c3_d;
        end
    end

    // R5
    dith_band_chk: assert property (@(posedge clk) disable iff (rst)
        (dith >= -4'sd3) && (dith <= 4'sd4));

    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc1_q == '0 && acc2_q == '0 && acc3_q == '0 && hist_q == '0));

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
    import fracn_pkg::*;
#(
    parameter int NINT_W   = DEF_NINT_W,
    parameter int HI_W     = DEF_HI_W,
    parameter int LO_W     = DEF_LO_W,
    parameter int MOD_W    = DEF_MOD_W,
    parameter int NINT_MIN = DEF_NINT_MIN,
    parameter int NINT_MAX = DEF_NINT_MAX,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nint_wr,
    input  logic [NINT_W-1:0] nint_data,
    input  logic              fhi_wr,
    input  logic [HI_W-1:0]   fhi_data,
    input  logic              flo_wr,
    input  logic [LO_W-1:0]   flo_data,
    input  logic              res_fine_i,
    input  logic              int_mode_i,
    input  logic [MOD_W-1:0]  mod_off_i,
    input  logic              cyc_i,
    output logic [NINT_W-1:0] modulus_o
);

    localparam int FRAC_W = HI_W + LO_W;
    localparam int WORD_W = NINT_W + FRAC_W + 1;

    logic [NINT_W-1:0]        act_nint;
    logic [HI_W-1:0]          act_hi;
    logic [LO_W-1:0]          act_lo;
    logic signed [MOD_W-1:0]  mod_s;
    logic [FRAC_W-1:0]        frac_sel;
    logic signed [WORD_W-1:0] off_ext;
    logic signed [WORD_W-1:0] word_eff;
    logic [NINT_W-1:0]        eff_int;
    logic [FRAC_W-1:0]        eff_frac;
    logic signed [DITH_W-1:0] dith;
    logic [NINT_W-1:0]        dith_ext;
    res_mode_e                res_mode;

    fracn_word_stage #(
        .NINT_W(NINT_W), .HI_W(HI_W), .LO_W(LO_W),
        .NINT_MIN(NINT_MIN), .NINT_MAX(NINT_MAX)
    ) u_words (
        .clk(clk), .rst(rst),
        .nint_wr(nint_wr), .nint_data(nint_data),
        .fhi_wr(fhi_wr), .fhi_data(fhi_data),
        .flo_wr(flo_wr), .flo_data(flo_data),
        .cyc_i(cyc_i),
        .act_nint(act_nint), .act_hi(act_hi), .act_lo(act_lo)
    );

    fracn_mod_sync #(.MOD_W(MOD_W), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst),
        .mod_in($signed(mod_off_i)),
        .mod_out(mod_s)
    );

    assign res_mode = res_mode_e'(res_fine_i);

    always_comb begin
        off_ext = {{(WORD_W-MOD_W){mod_s[MOD_W-1]}}, mod_s};
        if (res_mode == RES_FINE) begin
            frac_sel = {act_hi, act_lo};
        end else begin
            frac_sel = {act_hi, {LO_W{1'b0}}};
            off_ext  = off_ext <<< LO_W;
        end
        word_eff = $signed({1'b0, act_nint, frac_sel}) + off_ext;
        eff_int  = word_eff[FRAC_W +: NINT_W];
        eff_frac = word_eff[FRAC_W-1:0];
    end

    fracn_mash3 #(.FRAC_W(FRAC_W)) u_mash (
        .clk(clk), .rst(rst),
        .adv(cyc_i), .clr(int_mode_i),
        .x_in(eff_frac),
        .dith(dith)
    );

    assign dith_ext = {{(NINT_W-DITH_W){dith[DITH_W-1]}}, dith};

    always_ff @(posedge clk) begin
        if (rst)
            modulus_o <= NINT_W'(NINT_MIN);
        else if (cyc_i) begin
            if (int_mode_i)
                modulus_o <= act_nint;
            else
                modulus_o <= eff_int + dith_ext;
        end
    end

    // R2
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_i |=> $stable(modulus_o));

    // R6
    int_mode_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && int_mode_i) |=> (modulus_o == $past(act_nint)));

    // R5
    frac_band_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && !int_mode_i) |=>
            ((int'(modulus_o) - int'($past(eff_int)) >= -3) &&
             (int'(modulus_o) - int'($past(eff_int)) <= 4)));

endmodule

// File: tb/fracn_div_ctrl_test.sv
module fracn_div_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WIN = 8192;   // 2^13 strobes per averaging window

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nint_wr = 1'b0;
    logic [9:0]  nint_data = '0;
    logic        fhi_wr = 1'b0;
    logic [9:0]  fhi_data = '0;
    logic        flo_wr = 1'b0;
    logic [7:0]  flo_data = '0;
    logic        res_fine_i = 1'b1;
    logic        int_mode_i = 1'b0;
    logic [11:0] mod_off_i = '0;
    logic        cyc_i = 1'b0;
    logic [9:0]  modulus_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fracn_div_ctrl uut (
        .clk(clk), .rst(rst),
        .nint_wr(nint_wr), .nint_data(nint_data),
        .fhi_wr(fhi_wr), .fhi_data(fhi_data),
        .flo_wr(flo_wr), .flo_data(flo_data),
        .res_fine_i(res_fine_i), .int_mode_i(int_mode_i),
        .mod_off_i(mod_off_i), .cyc_i(cyc_i),
        .modulus_o(modulus_o)
    );

    task automatic check_eq(input longint act, input longint exp, input string req);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input longint act, input longint exp, input int tol, input string req);
        total++;
        if (act > exp + tol || act < exp - tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
        end
    endtask

    task automatic strobe_once();
        @(negedge clk); cyc_i = 1'b1;
        @(negedge clk); cyc_i = 1'b0;
    endtask

    // Consecutive strobes; each sample reflects the strobe just taken
    task automatic run_strobes(input int cnt, input int lo, input int hi,
                               output longint sum, output int bad);
        sum = 0; bad = 0;
        @(negedge clk); cyc_i = 1'b1;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            sum += modulus_o;
            if (int'(modulus_o) < lo || int'(modulus_o) > hi) bad++;
        end
        cyc_i = 1'b0;
    endtask

    task automatic write_words(input int n, input int hi, input int lo);
        @(negedge clk); fhi_wr = 1'b1; fhi_data = hi[9:0];
        @(negedge clk); fhi_wr = 1'b0;
        flo_wr = 1'b1; flo_data = lo[7:0];
        nint_wr = 1'b1; nint_data = n[9:0];
        @(negedge clk); flo_wr = 1'b0; nint_wr = 1'b0;
    endtask

    function automatic longint eff_word(input int n, input int hi, input int lo,
                                        input bit fine, input int off);
        longint f, o;
        f = fine ? longint'((hi << 8) | lo) : longint'(hi << 8);
        o = fine ? longint'(off) : longint'(off) * 256;
        return (longint'(n) <<< 18) + f + o;
    endfunction

    // Sum over WIN strobes of the current setup; checks mean and per-sample band
    task automatic check_window(input longint w, input string req);
        longint sum, dummy, ei;
        int bad, bd;
        ei = w >>> 18;
        run_strobes(8, 0, 1023, dummy, bd);
        run_strobes(WIN, int'(ei) - 3, int'(ei) + 4, sum, bad);
        check_near(sum, w >>> 5, 3, req);
        check_eq(bad, 0, "R5 band");
    endtask

    task automatic measure(input int n, input int hi, input int lo, input bit fine,
                           input int off, input string req);
        res_fine_i = fine;
        int_mode_i = 1'b0;
        mod_off_i  = off[11:0];
        write_words(n, hi, lo);
        check_window(eff_word(n, hi, lo, fine, off), req);
    endtask

    task automatic t_reset();
        longint s; int b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq(modulus_o, 32, "R1 reset value");
        run_strobes(64, 32, 32, s, b);
        check_eq(b, 0, "R1 F=0 stays 32");
    endtask

    task automatic t_commit_timing();
        int_mode_i = 1'b1;
        mod_off_i  = 12'd500;
        @(negedge clk); nint_wr = 1'b1; nint_data = 10'd100;
        @(negedge clk); nint_wr = 1'b0;
        strobe_once(); strobe_once();
        check_eq(modulus_o, 100, "R6 int mode ignores offset");
        @(negedge clk); nint_wr = 1'b1; nint_data = 10'd300;
        @(negedge clk); nint_wr = 1'b0;
        repeat (3) @(negedge clk);
        check_eq(modulus_o, 100, "R2 hold without strobe");
        strobe_once();
        check_eq(modulus_o, 100, "R9 first strobe keeps old");
        strobe_once();
        check_eq(modulus_o, 300, "R9 second strobe shows new");
        mod_off_i = '0;
    endtask

    task automatic t_saturate();
        int_mode_i = 1'b1;
        @(negedge clk); nint_wr = 1'b1; nint_data = 10'd5;
        @(negedge clk); nint_wr = 1'b0;
        strobe_once(); strobe_once();
        check_eq(modulus_o, 32, "R10 low clamp");
        @(negedge clk); nint_wr = 1'b1; nint_data = 10'd900;
        @(negedge clk); nint_wr = 1'b0;
        strobe_once(); strobe_once();
        check_eq(modulus_o, 543, "R10 high clamp");
    endtask

    task automatic t_fine();
        measure(150, 10'h123, 8'hE0, 1'b1, 0, "R3 mid fraction");
        measure(543, 10'h3FF, 8'hE0, 1'b1, 0, "R3 near-one fraction");
        measure(32,  10'h000, 8'h20, 1'b1, 0, "R3 tiny fraction");
    endtask

    task automatic t_coarse();
        measure(150, 10'h123, 8'hE0, 1'b0, 0, "R4 low part ignored");
    endtask

    task automatic t_offset();
        measure(100, 10'h100, 8'h00, 1'b1, 224, "R7 positive offset");
        measure(200, 10'h000, 8'h20, 1'b1, -64, "R7 borrow into integer");
        measure(100, 10'h100, 8'h00, 1'b0, 3, "R7 coarse offset unit");
    endtask

    task automatic t_atomic();
        measure(100, 10'h100, 8'h00, 1'b1, 0, "R3 base for R8");
        @(negedge clk); fhi_wr = 1'b1; fhi_data = 10'h200;
        @(negedge clk); fhi_wr = 1'b0;
        check_window(eff_word(100, 10'h100, 8'h00, 1'b1, 0), "R8 high write alone inert");
        @(negedge clk); flo_wr = 1'b1; flo_data = 8'h20;
        @(negedge clk); flo_wr = 1'b0;
        check_window(eff_word(100, 10'h200, 8'h20, 1'b1, 0), "R9 both halves committed");
    endtask

    initial begin
        t_reset();
        t_commit_timing();
        t_saturate();
        t_fine();
        t_coarse();
        t_offset();
        t_atomic();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule